// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Host Controller

This block drives an external serial successive-approximation converter from the host side. After reset it first runs a calibration. It pulses the converter's calibration line and waits for the converter's busy line to drop. Only then does it accept conversion requests. A conversion has a fixed order. The sample line is raised for a programmed acquisition window and then dropped. The controller then waits a programmed hold time and a programmed lead time. Next it sends exactly 17 gated clock pulses and shifts in 16 data bits, most significant bit first. The conversion clock never toggles while the sample line is high, except in the overlap described below.

In single mode, one pulse on `conv_go` starts one conversion. In continuous mode the controller chains conversions. It raises the sample line again during both phases of the 17th pulse, so the next acquisition starts at once. Each 16-bit two's complement result is presented on a valid/ready output. A new conversion stops before its first clock pulse until the previous result has been taken. A timeout watches every wait for busy to fall. If the timeout expires, the controller parks in a fault state until calibration is requested again.

States: CAL_HI, CAL_WAIT, IDLE, ACQ, HOLD, LEAD, CLK, DONE, FAULT.

Transitions:
- Any state goes to CAL_HI on `cal_req`.
- CAL_HI goes to CAL_WAIT when its pulse width has elapsed.
- CAL_WAIT goes to IDLE when busy falls, or to FAULT on timeout.
- IDLE goes to ACQ on `conv_go` or when continuous mode is set.
- ACQ goes to HOLD when the window has elapsed and busy is low, or to FAULT on timeout.
- HOLD goes to LEAD when the hold time has elapsed.
- LEAD goes to CLK when the lead time has elapsed and no result is pending.
- CLK goes to ACQ (rearmed) or to DONE after the 17th pulse.
- DONE goes to IDLE when busy falls, or to FAULT on timeout.
- FAULT is left only through `cal_req`.

Top module: `sar_host_ctrl`

## Requirements
- R1: Reset enters CAL_HI. `adc_cal` is high during reset and for exactly CAL_HI_CYC (default 4) cycles afterwards. Until busy falls after `adc_cal` drops, `adc_sample` and `adc_clk` stay low. A `cal_req` pulse repeats the sequence from any state.
- R2: In a single conversion, `adc_sample` stays high for `acq_cycles` cycles and falls only once busy is low. A programmed value of 0 acts as 1.
- R3: After `adc_sample` falls, `adc_clk` stays low for `hold_cycles` + `lead_cycles` cycles before the first pulse. A programmed value of 0 in either field acts as 1.
- R4: Each conversion has exactly 17 clock pulses, each one cycle high and one cycle low. Once `adc_sample` is high with `adc_clk` low, `adc_clk` stays low.
- R5: A bit is captured in the low phase of pulses 2 to 17. The bit from pulse 2 becomes `res_data[15]` and the bit from pulse 17 becomes `res_data[0]`. The two's complement value is passed unchanged.
- R6: `res_valid` rises in the cycle after the low phase of pulse 17. `res_data` holds stable while `res_valid` is high and `res_ready` is low. A handshake clears `res_valid`.
- R7: In IDLE, a one-cycle `conv_go` starts exactly one conversion. Without a request, no further sampling takes place.
- R8: When `cont_mode` is set at the end of pulse 16, `adc_sample` rises with the high phase of pulse 17 and stays high into the next acquisition.
- R9: While `res_valid` is high, the pulses of the next conversion do not start. They begin after the handshake, and the held sample is still converted.
- R10: If busy is still high after `tmo_cycles` consecutive wait cycles (0 acts as 1), `err_tmo` goes high. It then stays high with sample and clock low, and `conv_go` is ignored, until `cal_req` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_req | input | 1 | Request a calibration sequence |
| conv_go | input | 1 | Start one conversion from IDLE |
| cont_mode | input | 1 | Chain conversions back to back |
| acq_cycles | input | CW | Acquisition window in cycles |
| hold_cycles | input | CW | Sample-low hold in cycles |
| lead_cycles | input | CW | Further delay before the first pulse |
| tmo_cycles | input | TW | Bound on each busy-low wait |
| adc_cal | output | 1 | Converter calibration line |
| adc_sample | output | 1 | Converter sample line |
| adc_clk | output | 1 | Gated conversion clock |
| adc_busy | input | 1 | Converter busy line |
| adc_sdata | input | 1 | Converter serial data |
| res_data | output | DATA_W | Two's complement result |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| err_tmo | output | 1 | Busy timeout flag, held until recalibration |

## Verification
The assertions check, on every cycle, the properties that hold at each edge:
- pulses are one cycle wide;
- the clock stays quiet through an acquisition;
- sampling is blocked while calibration is pulsed;
- the result holds under backpressure;
- the fault flag is sticky and the lines stay quiet while it is set.

The bench's scenarios cover the properties that need a converter model and counting across a whole transaction:
- exact acquisition and lead lengths;
- the pulse count;
- bit order and sign;
- the rearm overlap in continuous mode;
- the stall that holds clocks back;
- the timeout path through recalibration.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

    typedef enum logic [3:0] {
        ST_CAL_HI,
        ST_CAL_WAIT,
        ST_IDLE,
        ST_ACQ,
        ST_HOLD,
        ST_LEAD,
        ST_CLK,
        ST_DONE,
        ST_FAULT
    } host_state_t;

endpackage

// File: rtl/sar_host_delay.sv
module sar_host_delay #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         done
);

    logic [W-1:0] cnt;
    logic [W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
        // a limit of zero is reached at once, so it behaves as one cycle
        done    = (cnt_inc >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sar_host_capture.sv
module sar_host_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              commit,
    input  logic              sdata,
    input  logic              ready,
    output logic [DATA_W-1:0] data,
    output logic              valid
);

    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            if (shift_en) begin
                shreg <= {shreg[DATA_W-2:0], sdata};
            end
            if (commit) begin
                data  <= {shreg[DATA_W-2:0], sdata};
                valid <= 1'b1;
            end else if (valid && ready) begin
                valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sar_host_ctrl.sv
module sar_host_ctrl
    import sar_host_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CW         = 16,
    parameter int TW         = 20,
    parameter int CAL_HI_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_req,
    input  logic              conv_go,
    input  logic              cont_mode,
    input  logic [CW-1:0]     acq_cycles,
    input  logic [CW-1:0]     hold_cycles,
    input  logic [CW-1:0]     lead_cycles,
    input  logic [TW-1:0]     tmo_cycles,
    output logic              adc_cal,
    output logic              adc_sample,
    output logic              adc_clk,
    input  logic              adc_busy,
    input  logic              adc_sdata,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              err_tmo
);

    localparam int            NPULSE    = DATA_W + 1;
    localparam int            PCW       = $clog2(NPULSE + 1);
    localparam logic [PCW-1:0] P_FIRST  = PCW'(1);
    localparam logic [PCW-1:0] P_DATA0  = PCW'(2);
    localparam logic [PCW-1:0] P_LAST   = PCW'(NPULSE);
    localparam logic [PCW-1:0] P_ARM    = PCW'(NPULSE - 1);
    localparam logic [CW-1:0]  CAL_LIM  = CW'(CAL_HI_CYC);

    host_state_t    state, nstate;
    logic           phase;      // 0: clock high half, 1: clock low half
    logic [PCW-1:0] pcnt;
    logic           rearm;

    logic [CW-1:0]  dly_limit;
    logic           dly_done, dly_clr;
    logic           wait_busy, tmo_en, tmo_clr, tmo_done, tmo_hit;
    logic           shift_en, commit;

    // ---- phase delay timer ----
    always_comb begin
        unique case (state)
            ST_CAL_HI: dly_limit = CAL_LIM;
            ST_ACQ:    dly_limit = acq_cycles;
            ST_HOLD:   dly_limit = hold_cycles;
            ST_LEAD:   dly_limit = lead_cycles;
            default:   dly_limit = CW'(1);
        endcase
    end

    assign dly_clr = (nstate != state);

    sar_host_delay #(.W(CW)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dly_clr),
        .en    (1'b1),
        .limit (dly_limit),
        .done  (dly_done)
    );

    // ---- busy-fall watchdog ----
    assign wait_busy = (state == ST_CAL_WAIT) || (state == ST_DONE) ||
                       ((state == ST_ACQ) && dly_done);
    assign tmo_en    = wait_busy && adc_busy;
    assign tmo_clr   = !wait_busy || (nstate != state);
    assign tmo_hit   = tmo_en && tmo_done;

    sar_host_delay #(.W(TW)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmo_clr),
        .en    (tmo_en),
        .limit (tmo_cycles),
        .done  (tmo_done)
    );

    // ---- next state ----
    always_comb begin
        nstate = state;
        if (cal_req) begin
            nstate = ST_CAL_HI;
        end else begin
            unique case (state)
                ST_CAL_HI:   if (dly_done) nstate = ST_CAL_WAIT;
                ST_CAL_WAIT: begin
                    if (!adc_busy)    nstate = ST_IDLE;
                    else if (tmo_hit) nstate = ST_FAULT;
                end
                ST_IDLE:     if (conv_go || cont_mode) nstate = ST_ACQ;
                ST_ACQ: begin
                    if (dly_done && !adc_busy) nstate = ST_HOLD;
                    else if (tmo_hit)          nstate = ST_FAULT;
                end
                ST_HOLD:     if (dly_done) nstate = ST_LEAD;
                ST_LEAD:     if (dly_done && !res_valid) nstate = ST_CLK;
                ST_CLK: begin
                    if (phase && (pcnt == P_LAST)) nstate = rearm ? ST_ACQ : ST_DONE;
                end
                ST_DONE: begin
                    if (!adc_busy)    nstate = ST_IDLE;
                    else if (tmo_hit) nstate = ST_FAULT;
                end
                ST_FAULT:    nstate = ST_FAULT;
                default:     nstate = ST_CAL_HI;
            endcase
        end
    end

    // ---- state register and pulse sequencer ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CAL_HI;
            phase <= 1'b0;
            pcnt  <= P_FIRST;
            rearm <= 1'b0;
        end else begin
            state <= nstate;
            if (state != ST_CLK) begin
                phase <= 1'b0;
                pcnt  <= P_FIRST;
            end else begin
                phase <= ~phase;
                if (phase) pcnt <= pcnt + 1'b1;
                if (phase && (pcnt == P_ARM)) rearm <= cont_mode;
            end
        end
    end

    // ---- outputs ----
    always_comb begin
        adc_cal    = (state == ST_CAL_HI);
        adc_sample = (state == ST_ACQ) ||
                     ((state == ST_CLK) && (pcnt == P_LAST) && rearm);
        adc_clk    = (state == ST_CLK) && !phase;
        err_tmo    = (state == ST_FAULT);
        shift_en   = (state == ST_CLK) && phase && (pcnt >= P_DATA0);
        commit     = (state == ST_CLK) && phase && (pcnt == P_LAST);
    end

    sar_host_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .commit   (commit),
        .sdata    (adc_sdata),
        .ready    (res_ready),
        .data     (res_data),
        .valid    (res_valid)
    );

endmodule

// File: rtl/sar_host_chk.sv
module sar_host_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_req,
    input logic              adc_cal,
    input logic              adc_sample,
    input logic              adc_clk,
    input logic [DATA_W-1:0] res_data,
    input logic              res_valid,
    input logic              res_ready,
    input logic              err_tmo
);

    // R4
    clk_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_clk |=> !adc_clk);

    // R4
    clk_quiet_in_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sample && !adc_clk) |=> !adc_clk);

    // R1
    cal_blocks_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cal |-> (!adc_sample && !adc_clk));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

    // R10
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_tmo && !cal_req) |=> err_tmo);

    // R10
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmo |-> (!adc_sample && !adc_clk && !adc_cal));

endmodule

bind sar_host_ctrl sar_host_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_req    (cal_req),
    .adc_cal    (adc_cal),
    .adc_sample (adc_sample),
    .adc_clk    (adc_clk),
    .res_data   (res_data),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .err_tmo    (err_tmo)
);

// File: tb/tb_sar_host_ctrl.sv
`timescale 1ns/1ps
module tb_sar_host_ctrl;

    localparam int DW = 16;
    localparam int CW = 16;
    localparam int TW = 20;
    localparam int NV = 8;
    // {code, acq, hold, lead}
    localparam logic [39:0] VEC [NV] = '{
        {16'h0000, 8'd1, 8'd1, 8'd1},
        {16'h7FFF, 8'd5, 8'd2, 8'd3},
        {16'h8000, 8'd0, 8'd0, 8'd0},
        {16'hFFFF, 8'd3, 8'd4, 8'd1},
        {16'h5A5A, 8'd8, 8'd1, 8'd6},
        {16'hA5C3, 8'd2, 8'd3, 8'd2},
        {16'h0001, 8'd1, 8'd1, 8'd4},
        {16'hC000, 8'd6, 8'd2, 8'd2}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, cal_req, conv_go, cont_mode, res_ready;
    logic [CW-1:0] acq_cycles, hold_cycles, lead_cycles;
    logic [TW-1:0] tmo_cycles;
    logic          adc_cal, adc_sample, adc_clk, res_valid, err_tmo;
    logic [DW-1:0] res_data;

    // converter model state
    logic          m_busy, m_sdata, m_in_cal, m_in_conv;
    logic          p_samp, p_clk, p_cal;
    logic [DW-1:0] m_val;
    logic [DW-1:0] model_code;
    int            m_pc, m_gap, m_acq, m_calhi, m_calcnt;
    int            gate_bad, rearm_seen, samp_in_cal;
    int            cal_dur;

    sar_host_ctrl #(.DATA_W(DW), .CW(CW), .TW(TW), .CAL_HI_CYC(4)) dut (
        .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .conv_go(conv_go),
        .cont_mode(cont_mode), .acq_cycles(acq_cycles), .hold_cycles(hold_cycles),
        .lead_cycles(lead_cycles), .tmo_cycles(tmo_cycles), .adc_cal(adc_cal),
        .adc_sample(adc_sample), .adc_clk(adc_clk), .adc_busy(m_busy),
        .adc_sdata(m_sdata), .res_data(res_data), .res_valid(res_valid),
        .res_ready(res_ready), .err_tmo(err_tmo)
    );

    always @(posedge clk) begin
        p_samp <= adc_sample;
        p_clk  <= adc_clk;
        p_cal  <= adc_cal;
        if (!rst_n) begin
            m_busy <= 1'b0; m_sdata <= 1'b0; m_in_cal <= 1'b0; m_in_conv <= 1'b0;
            m_val <= '0; m_pc <= 0; m_gap <= 0; m_acq <= 0; m_calhi <= 0; m_calcnt <= 0;
            gate_bad <= 0; rearm_seen <= 0; samp_in_cal <= 0;
        end else if (adc_cal) begin
            m_busy <= 1'b1; m_in_cal <= 1'b1; m_in_conv <= 1'b0; m_calcnt <= 0;
            m_calhi <= p_cal ? m_calhi + 1 : 1;
        end else if (m_in_cal) begin
            if (adc_sample || adc_clk) samp_in_cal <= samp_in_cal + 1;
            if (m_calcnt + 1 >= cal_dur) begin
                m_busy <= 1'b0; m_in_cal <= 1'b0;
            end else begin
                m_calcnt <= m_calcnt + 1;
            end
        end else begin
            if (adc_sample && !p_samp) m_acq <= 1;
            else if (adc_sample)       m_acq <= m_acq + 1;
            if (adc_clk && !p_clk && adc_sample) begin
                if (m_in_conv && (m_pc + 1 == DW + 1)) rearm_seen <= rearm_seen + 1;
                else                                   gate_bad <= gate_bad + 1;
            end
            if (!adc_sample && p_samp && !m_busy) begin
                m_in_conv <= 1'b1; m_busy <= 1'b1; m_pc <= 0; m_gap <= 1; m_val <= model_code;
            end else if (m_in_conv) begin
                if (adc_clk && !p_clk) begin
                    m_pc <= m_pc + 1;
                    if (m_pc + 1 >= 2 && m_pc + 1 <= DW + 1) m_sdata <= m_val[DW - m_pc];
                end else if (!adc_clk && m_pc == 0) begin
                    m_gap <= m_gap + 1;
                end
                if (!adc_clk && p_clk && m_pc == DW + 1) begin
                    m_busy <= 1'b0; m_in_conv <= 1'b0;
                end
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_cal();
        @(negedge clk); cal_req = 1'b1;
        @(negedge clk); cal_req = 1'b0;
    endtask

    task automatic wait_cal_done(input string req);
        bit ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!adc_cal && !m_in_cal && !m_busy) begin ok = 1'b1; break; end
        end
        check(ok, req, int'(ok), 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_valid(input string req);
        bit ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (res_valid) begin ok = 1'b1; break; end
        end
        check(ok, req, int'(ok), 1);
    endtask

    initial begin
        #(4ns * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cal_req = 1'b0; conv_go = 1'b0; cont_mode = 1'b0; res_ready = 1'b1;
        acq_cycles = 16'd4; hold_cycles = 16'd2; lead_cycles = 16'd2; tmo_cycles = 20'd1000;
        model_code = '0; cal_dur = 60;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(adc_cal == 1'b1, "R1 cal high in reset", int'(adc_cal), 1);
        check(!adc_sample && !adc_clk, "R1 sample/clk low in reset", int'({adc_sample, adc_clk}), 0);
        check(!res_valid && !err_tmo, "R6 no result in reset", int'({res_valid, err_tmo}), 0);
        rst_n = 1'b1;
        wait_cal_done("R1 power-up calibration completes");
        check(samp_in_cal == 0, "R1 quiet during calibration", samp_in_cal, 0);

        pulse_cal();
        wait_cal_done("R1 requested calibration completes");
        check(m_calhi == 4, "R1 cal pulse width", m_calhi, 4);
        check(samp_in_cal == 0, "R1 quiet during requested calibration", samp_in_cal, 0);

        // vector walk: single conversions
        for (int v = 0; v < NV; v++) begin
            logic [DW-1:0] code;
            int a, h, l;
            code = VEC[v][39:24];
            a = (VEC[v][23:16] == 0) ? 1 : int'(VEC[v][23:16]);
            h = (VEC[v][15:8]  == 0) ? 1 : int'(VEC[v][15:8]);
            l = (VEC[v][7:0]   == 0) ? 1 : int'(VEC[v][7:0]);
            acq_cycles  = CW'(VEC[v][23:16]);
            hold_cycles = CW'(VEC[v][15:8]);
            lead_cycles = CW'(VEC[v][7:0]);
            model_code  = code;
            @(negedge clk); conv_go = 1'b1;
            @(negedge clk); conv_go = 1'b0;
            wait_valid("R7 single conversion yields result");
            check(res_data == code, "R5 bit order and sign", int'(res_data), int'(code));
            check(($signed(res_data) < 0) == code[DW-1], "R5 two's complement sign", int'(res_data[DW-1]), int'(code[DW-1]));
            check(m_acq == a, "R2 acquisition length", m_acq, a);
            check(m_gap == h + l, "R3 delay to first pulse", m_gap, h + l);
            check(m_pc == DW + 1 && !adc_clk, "R6 valid after pulse 17", m_pc, DW + 1);
            repeat (6) @(negedge clk);
            check(!m_in_conv && !res_valid, "R7 one conversion per request", int'(m_in_conv), 0);
        end
        check(gate_bad == 0, "R4 clock gated in acquisition", gate_bad, 0);

        // continuous with backpressure
        res_ready = 1'b0; acq_cycles = 16'd3; hold_cycles = 16'd2; lead_cycles = 16'd2;
        model_code = 16'h1234;
        @(negedge clk); cont_mode = 1'b1;
        wait_valid("R8 continuous first result");
        check(res_data == 16'h1234, "R8 continuous first data", int'(res_data), 16'h1234);
        model_code = 16'hE321;
        repeat (150) @(negedge clk);
        check(rearm_seen == 1, "R8 sample raised in pulse 17", rearm_seen, 1);
        check(res_valid && res_data == 16'h1234, "R6 result held under backpressure", int'(res_data), 16'h1234);
        check(m_in_conv && m_pc == 0, "R9 clocks stalled while result pending", m_pc, 0);
        cont_mode = 1'b0; res_ready = 1'b1;
        @(negedge clk);
        wait_valid("R9 stalled conversion resumes");
        check(res_data == 16'hE321, "R9 held sample converted", int'(res_data), 16'hE321);
        repeat (100) @(negedge clk);
        check(!m_in_conv && rearm_seen == 1, "R8 chain ends without mode", rearm_seen, 1);
        check(gate_bad == 0, "R4 no stray clock in continuous", gate_bad, 0);

        // timeout during calibration
        tmo_cycles = 20'd10;
        pulse_cal();
        repeat (100) @(negedge clk);
        check(err_tmo == 1'b1, "R10 timeout flag raised", int'(err_tmo), 1);
        begin
            int highs = 0;
            @(negedge clk); conv_go = 1'b1;
            @(negedge clk); conv_go = 1'b0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (adc_sample || adc_clk) highs++;
            end
            check(highs == 0, "R10 conversions blocked in fault", highs, 0);
        end
        check(err_tmo == 1'b1, "R10 flag sticky", int'(err_tmo), 1);
        tmo_cycles = 20'd1000;
        pulse_cal();
        wait_cal_done("R10 recalibration after fault");
        check(err_tmo == 1'b0, "R10 flag cleared by calibration", int'(err_tmo), 0);
        model_code = 16'h8001; acq_cycles = 16'd2;
        @(negedge clk); conv_go = 1'b1;
        @(negedge clk); conv_go = 1'b0;
        wait_valid("R7 conversion after recovery");
        check(res_data == 16'h8001, "R5 data after recovery", int'(res_data), 16'h8001);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule